// File: doc/BRIEF.md
# Multi-Source Interrupt Controller with Wake

This block collects four interrupt sources and turns them into a single interrupt request for the CPU and a separate wake-up request for sleep mode. The four sources are an external pin that triggers on an edge of selectable polarity, an overflow pulse from an 8-bit timer, a change on any of a group of port pins, and a pulse that marks the end of a nonvolatile write. Each source has a sticky flag and an enable bit. A global enable gates the CPU request.

Software reaches the controller through a two-register port. Address 0 holds the control bits and address 1 holds the flags. A flag is set by its event whether or not it is masked, and software clears it by writing. The CPU pulses an acknowledge when it takes an interrupt, which clears the global enable. A return strobe sets the global enable again. The block also outputs a fixed vector address. While the CPU sleeps, an enabled and flagged source raises the wake request even if the global enable is clear. The timer cannot take part in wake-up, because its clock is stopped during sleep.

The external pin and the port pins arrive asynchronously and pass through a parameterised synchroniser. The port-change detector compares the synchronised pins with a snapshot. The snapshot is reloaded whenever the CPU reads the port, which the CPU signals with a strobe.

Top module: `irq_hub`

## Requirements
- R1: After reset, the control register (address 0) reads 0x40: global enable (bit 7) clear, edge polarity (bit 6) set for rising, and enables (bits 3:0) clear. The flag register (address 1) reads 0. The interrupt and wake outputs are low.
- R2: The external-pin flag (flag bit 0) is set by a rising edge when the polarity bit is 1, and by a falling edge when it is 0. The opposite edge has no effect. The flag appears SYNC_STAGES+1 clock edges after the pin is first sampled at its new level.
- R3: Flag bits are 0 external pin, 1 timer overflow, 2 port change and 3 write done. A flag stays set until a write to address 1 replaces the flag bits with write-data bits 3:0. An event in the same cycle as that write leaves its flag set.
- R4: The interrupt request is high exactly when the global enable is set and at least one flag has its matching enable (control bits 3:0, same order as the flags) set. A flag still sets while its enable or the global enable is clear.
- R5: An acknowledge pulse clears the global enable at the next edge. It takes priority over a return strobe and over a control write in the same cycle.
- R6: A return strobe sets the global enable. If a flag and its enable are still set, the interrupt request reasserts.
- R7: The vector address output equals VEC_ADDR (4 by default) at all times.
- R8: While sleep is high, the wake request is high exactly when a flag other than the timer flag has its enable set, whatever the global enable. With the global enable clear, the interrupt request stays low.
- R9: A timer overflow pulse while sleep is high does not set the timer flag.
- R10: The port-change flag is set while the synchronised port pins differ from the snapshot. A port-read strobe loads the snapshot with the synchronised pins, after which a cleared flag stays clear until the pins change again.
- R11: A write-done pulse sets flag bit 3 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| port_pins | input | PORT_W | Watched port pins, asynchronous |
| port_rd | input | 1 | Strobe: CPU read the port, reload snapshot |
| tmr_ovf | input | 1 | Timer wrap pulse from FFh to 00h |
| nvm_done | input | 1 | Nonvolatile write complete pulse |
| sleep | input | 1 | CPU is in sleep mode |
| reg_addr | input | 1 | 0 selects control, 1 selects flags |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| irq_ack | input | 1 | CPU took the interrupt, clear global enable |
| irq_ret | input | 1 | Return from interrupt, set global enable |
| irq_req | output | 1 | Interrupt request to the CPU |
| wake_req | output | 1 | Wake request during sleep |
| vec_addr | output | VEC_W | Interrupt vector address |

## Verification
The bench builds the block with SYNC_STAGES set to 3 instead of the default 2. This makes the edge and change latencies depend on the parameter, not on a fixed two-flop delay, and it exposes any off-by-one in the synchroniser chain. PORT_W is 4 and VEC_ADDR is 4. With these values the bench can check the falling-edge and rising-edge modes, the snapshot reload on a port read, and the sleep cases in which the timer is masked out of wake while the other sources wake with the global enable clear.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

   localparam int NSRC = 4;

   // flag / enable bit positions (software decodes these)
   localparam int SRC_EXT  = 0;
   localparam int SRC_TMR  = 1;
   localparam int SRC_PORT = 2;
   localparam int SRC_NVM  = 3;

   localparam logic ADDR_CTRL = 1'b0;
   localparam logic ADDR_FLAG = 1'b1;

   typedef struct packed {
      logic            gie;
      logic            rise;
      logic [NSRC-1:0] en;
   } ctrl_t;

   localparam ctrl_t CTRL_RESET = '{gie: 1'b0, rise: 1'b1, en: '0};

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("irq_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("irq_sync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/irq_event_detect.sv
module irq_event_detect #(
   parameter int PORT_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_pin,
   input  logic [PORT_W-1:0] port_pins,
   input  logic              port_rd,
   input  logic              rise_sel,
   output logic              ext_ev,
   output logic              port_ev
);

   logic              ext_s;
   logic              ext_prev;
   logic [PORT_W-1:0] port_s;
   logic [PORT_W-1:0] port_snap;

   irq_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_ext (
      .clk(clk), .rst_n(rst_n), .d(ext_pin), .q(ext_s)
   );

   irq_sync #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync_port (
      .clk(clk), .rst_n(rst_n), .d(port_pins), .q(port_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_prev  <= 1'b0;
         port_snap <= '0;
      end else begin
         ext_prev <= ext_s;
         if (port_rd) port_snap <= port_s;
      end
   end

   assign ext_ev  = rise_sel ? (ext_s & ~ext_prev) : (~ext_s & ext_prev);
   assign port_ev = (port_s != port_snap);

   // one edge yields a one-cycle event unless polarity flips in between
   assert_edge_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ext_ev |=> (!ext_ev || !$stable(rise_sel)));

endmodule

// File: rtl/irq_hub.sv
module irq_hub
   import irq_hub_pkg::*;
#(
   parameter int PORT_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int VEC_W       = 13,
   parameter int VEC_ADDR    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_pin,
   input  logic [PORT_W-1:0] port_pins,
   input  logic              port_rd,
   input  logic              tmr_ovf,
   input  logic              nvm_done,
   input  logic              sleep,
   input  logic              reg_addr,
   input  logic              reg_we,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              irq_ack,
   input  logic              irq_ret,
   output logic              irq_req,
   output logic              wake_req,
   output logic [VEC_W-1:0]  vec_addr
);

   if (PORT_W < 1) begin : g_bad_port
      $error("irq_hub: PORT_W must be at least 1");
   end
   if (VEC_W < 1 || VEC_W > 31 || VEC_ADDR < 0 || VEC_ADDR >= (1 << VEC_W)) begin : g_bad_vec
      $error("irq_hub: VEC_ADDR does not fit VEC_W");
   end

   logic            ext_ev, port_ev;
   logic [NSRC-1:0] ev;
   logic [NSRC-1:0] flags_q, flags_nxt;
   logic [NSRC-1:0] pend, wake_pend;
   ctrl_t           ctrl_q;
   logic            flag_wr, ctrl_wr;
   logic            unused_wbits;

   assign unused_wbits = ^reg_wdata[5:4];

   irq_event_detect #(.PORT_W(PORT_W), .SYNC_STAGES(SYNC_STAGES)) u_detect (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_pin  (ext_pin),
      .port_pins(port_pins),
      .port_rd  (port_rd),
      .rise_sel (ctrl_q.rise),
      .ext_ev   (ext_ev),
      .port_ev  (port_ev)
   );

   assign ev[SRC_EXT]  = ext_ev;
   assign ev[SRC_TMR]  = tmr_ovf & ~sleep;   // timer clock stopped in sleep
   assign ev[SRC_PORT] = port_ev;
   assign ev[SRC_NVM]  = nvm_done;

   assign flag_wr = reg_we & (reg_addr == ADDR_FLAG);
   assign ctrl_wr = reg_we & (reg_addr == ADDR_CTRL);

   always_comb begin
      flags_nxt = flag_wr ? reg_wdata[NSRC-1:0] : flags_q;
      flags_nxt = flags_nxt | ev;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= flags_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RESET;
      end else begin
         if (ctrl_wr) begin
            ctrl_q.gie  <= reg_wdata[7];
            ctrl_q.rise <= reg_wdata[6];
            ctrl_q.en   <= reg_wdata[NSRC-1:0];
         end
         if (irq_ret) ctrl_q.gie <= 1'b1;
         if (irq_ack) ctrl_q.gie <= 1'b0;
      end
   end

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign pend[s] = flags_q[s] & ctrl_q.en[s];
      if (s == SRC_TMR) begin : g_no_wake
         assign wake_pend[s] = 1'b0;
      end else begin : g_wake
         assign wake_pend[s] = pend[s];
      end
   end

   assign irq_req   = ctrl_q.gie & (|pend);
   assign wake_req  = sleep & (|wake_pend);
   assign vec_addr  = VEC_W'(VEC_ADDR);
   assign reg_rdata = (reg_addr == ADDR_FLAG) ? {{(8-NSRC){1'b0}}, flags_q}
                                              : {ctrl_q.gie, ctrl_q.rise, 2'b00, ctrl_q.en};

   assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> !ctrl_q.gie);

   assert_ret_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ret && !irq_ack) |=> ctrl_q.gie);

   assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_wr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

   assert_timer_asleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep && !flag_wr) |=> !$rose(flags_q[SRC_TMR]));

endmodule

// File: tb/irq_hub_test.sv
module irq_hub_test;

   localparam int CLK_PERIOD = 10;
   localparam int SYNC       = 3;
   localparam int PW         = 4;
   localparam int VW         = 13;
   localparam int VEC        = 4;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          ext_pin, port_rd, tmr_ovf, nvm_done, sleep;
   logic [PW-1:0] port_pins;
   logic          reg_addr, reg_we, irq_ack, irq_ret;
   logic [7:0]    reg_wdata;
   logic [7:0]    reg_rdata;
   logic          irq_req, wake_req;
   logic [VW-1:0] vec_addr;

   int n_checks = 0;
   int n_fail   = 0;
   bit model_on = 0;

   irq_hub #(.PORT_W(PW), .SYNC_STAGES(SYNC), .VEC_W(VW), .VEC_ADDR(VEC)) uut (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .port_pins(port_pins),
      .port_rd(port_rd), .tmr_ovf(tmr_ovf), .nvm_done(nvm_done), .sleep(sleep),
      .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_ack(irq_ack), .irq_ret(irq_ret),
      .irq_req(irq_req), .wake_req(wake_req), .vec_addr(vec_addr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(string tag, int got, int exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
      end
   endtask

   // behavioural reference model
   bit [3:0]    m_flags, m_en;
   bit          m_gie, m_rise;
   bit [PW-1:0] m_snap;
   bit          h_ext[$];
   bit [PW-1:0] h_port[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_flags = 0; m_en = 0; m_gie = 0; m_rise = 1; m_snap = 0;
         h_ext.delete(); h_port.delete();
         for (int i = 0; i <= SYNC; i++) begin
            h_ext.push_back(1'b0);
            h_port.push_back('0);
         end
      end else begin
         bit          e_now, e_old, ev_e, ev_p;
         bit [PW-1:0] p_now;
         bit [3:0]    nf;
         h_ext.push_back(ext_pin);
         h_port.push_back(port_pins);
         e_now = h_ext[h_ext.size()-1-SYNC];
         e_old = h_ext[h_ext.size()-2-SYNC];
         p_now = h_port[h_port.size()-1-SYNC];
         ev_e  = m_rise ? (e_now && !e_old) : (!e_now && e_old);
         ev_p  = (p_now != m_snap);
         nf = (reg_we && reg_addr) ? reg_wdata[3:0] : m_flags;
         if (ev_e) nf[0] = 1;
         if (tmr_ovf && !sleep) nf[1] = 1;
         if (ev_p) nf[2] = 1;
         if (nvm_done) nf[3] = 1;
         m_flags = nf;
         if (reg_we && !reg_addr) begin
            m_gie = reg_wdata[7]; m_rise = reg_wdata[6]; m_en = reg_wdata[3:0];
         end
         if (irq_ret) m_gie = 1;
         if (irq_ack) m_gie = 0;
         if (port_rd) m_snap = p_now;
         while (h_ext.size() > SYNC + 2) begin
            void'(h_ext.pop_front());
            void'(h_port.pop_front());
         end
      end
      #1;
      if (model_on) begin
         bit [3:0] p;
         p = m_flags & m_en;
         chk("R4 irq_req vs model", irq_req, int'(m_gie && (p != 0)));
         chk("R8 wake_req vs model", wake_req, int'(sleep && ((p & 4'b1101) != 0)));
         chk("R3 reg_rdata vs model", reg_rdata,
             reg_addr ? int'(m_flags) : int'({m_gie, m_rise, 2'b00, m_en}));
         chk("R7 vec_addr", vec_addr, VEC);
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(bit a, logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1;
      @(negedge clk);
      reg_we = 0;
   endtask

   task automatic rd_chk(string tag, bit a, int exp);
      reg_addr = a;
      #1;
      chk(tag, reg_rdata, exp);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++; n_fail++;
      $display("FAIL R1 watchdog: got 0 expected 1 (run did not finish)");
      summary();
      $finish;
   end

   initial begin
      rst_n = 0; ext_pin = 0; port_pins = '0; port_rd = 0; tmr_ovf = 0;
      nvm_done = 0; sleep = 0; reg_addr = 0; reg_we = 0; reg_wdata = '0;
      irq_ack = 0; irq_ret = 0;
      tick(4);
      rst_n = 1;
      model_on = 1;
      tick(1);

      // R1 reset state
      rd_chk("R1 ctrl reset", 0, 8'h40);
      rd_chk("R1 flags reset", 1, 0);
      chk("R1 irq reset", irq_req, 0);
      chk("R1 wake reset", wake_req, 0);

      // R2 edge polarity
      ext_pin = 1; tick(SYNC + 3);
      rd_chk("R2 rising sets", 1, 1);
      wr(1, 8'h00);
      ext_pin = 0; tick(SYNC + 3);
      rd_chk("R2 falling ignored when rising", 1, 0);
      wr(0, 8'h00);
      ext_pin = 1; tick(SYNC + 3);
      rd_chk("R2 rising ignored when falling", 1, 0);
      ext_pin = 0; tick(SYNC + 3);
      rd_chk("R2 falling sets", 1, 1);
      wr(1, 8'h00);
      wr(0, 8'h40);

      // R11 / R4 masked flag
      nvm_done = 1; tick(1); nvm_done = 0;
      rd_chk("R11 write-done flag", 1, 8);
      chk("R4 masked no irq", irq_req, 0);
      wr(0, 8'h48);
      chk("R4 gie clear no irq", irq_req, 0);
      wr(0, 8'hC8);
      chk("R4 irq asserted", irq_req, 1);

      // R5 acknowledge
      irq_ack = 1; tick(1); irq_ack = 0;
      chk("R5 ack drops irq", irq_req, 0);
      rd_chk("R5 gie cleared", 0, 8'h48);

      // R6 return re-requests
      irq_ret = 1; tick(1); irq_ret = 0;
      chk("R6 ret reasserts irq", irq_req, 1);
      rd_chk("R6 gie set", 0, 8'hC8);

      // R5 ack beats ret
      irq_ack = 1; irq_ret = 1; tick(1); irq_ack = 0; irq_ret = 0;
      chk("R5 ack over ret", irq_req, 0);

      // R3 event wins over clearing write
      nvm_done = 1; wr(1, 8'h00); nvm_done = 0;
      rd_chk("R3 event beats clear", 1, 8);
      wr(1, 8'h00);
      rd_chk("R3 cleared by write", 1, 0);

      // R9 / R8 sleep behaviour
      wr(0, 8'h4F);
      sleep = 1; tmr_ovf = 1; tick(1); tmr_ovf = 0;
      rd_chk("R9 timer ignored asleep", 1, 0);
      chk("R9 no wake", wake_req, 0);
      sleep = 0; tmr_ovf = 1; tick(1); tmr_ovf = 0;
      rd_chk("R9 timer sets awake", 1, 2);
      chk("R4 gie clear blocks timer", irq_req, 0);
      sleep = 1; #1;
      chk("R8 timer cannot wake", wake_req, 0);
      wr(1, 8'h00);
      nvm_done = 1; tick(1); nvm_done = 0;
      chk("R8 wake with gie clear", wake_req, 1);
      chk("R8 irq stays low", irq_req, 0);
      sleep = 0; #1;
      chk("R8 no wake when awake", wake_req, 0);
      wr(1, 8'h00);

      // R10 port change
      port_pins = 4'b0100; tick(SYNC + 3);
      rd_chk("R10 change sets", 1, 4);
      port_rd = 1; tick(1); port_rd = 0;
      wr(1, 8'h00); tick(SYNC + 3);
      rd_chk("R10 quiet after read", 1, 0);
      port_pins = 4'b0000; tick(SYNC + 3);
      rd_chk("R10 change back sets", 1, 4);
      port_rd = 1; tick(1); port_rd = 0;
      wr(1, 8'h00);

      // R7
      chk("R7 vector", vec_addr, VEC);

      // mixed stimulus, model compared each clock
      for (int i = 0; i < 600; i++) begin
         ext_pin  = ($urandom_range(0, 5) == 0) ? ~ext_pin : ext_pin;
         if ($urandom_range(0, 7) == 0) port_pins = PW'($urandom);
         port_rd  = ($urandom_range(0, 5) == 0);
         tmr_ovf  = ($urandom_range(0, 6) == 0);
         nvm_done = ($urandom_range(0, 9) == 0);
         if ($urandom_range(0, 15) == 0) sleep = ~sleep;
         irq_ack  = ($urandom_range(0, 9) == 0);
         irq_ret  = ($urandom_range(0, 9) == 0);
         reg_addr = 1'($urandom);
         reg_we   = ($urandom_range(0, 7) == 0);
         reg_wdata = 8'($urandom);
         tick(1);
      end
      reg_we = 0; irq_ack = 0; irq_ret = 0; tmr_ovf = 0; nvm_done = 0; port_rd = 0;
      tick(2);
      summary();
      $finish;
   end

endmodule